// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the integer register file of a 32-bit core that runs in one of four operating modes: user, fast interrupt, interrupt and supervisor. Software sees sixteen registers, numbered 0 to 15. Behind some of those numbers sit several physical copies, and the mode that is currently active decides which copy a read or a write reaches. Registers 0 to 7 exist only once. Registers 8 to 12 have one copy that belongs to the fast-interrupt mode and a second copy that every other mode shares. Registers 13 and 14 have one copy for each mode.

Register 15 is the program counter. It is held as a 24-bit word address and always reads back as a 32-bit byte address with its top and bottom bits at zero. The block has two combinational read ports and one write port. It also has a program-counter write port of its own and a user-bank override. When the override is asserted, reads and writes reach the user copies from any mode, so a privileged routine can move user registers.

Top module: `bank_regfile`

## Requirements
- R1: `mode_i` is encoded as 0 = user, 1 = fast interrupt, 2 = interrupt and 3 = supervisor. Registers 0 to 7 have one copy each, so a value written in any mode reads back in every mode.
- R2: Registers 8 to 12 have two copies. A write in mode 1 is seen only in mode 1. A write in modes 0, 2 or 3 is seen in all three of those modes and not in mode 1.
- R3: Registers 13 and 14 have four copies, one for each mode. A write reaches only the copy of the mode that is active at that time.
- R4: Writes take effect at the rising clock edge, using the mode present at that edge. Reads are combinational and have no bypass, so a register read in the cycle it is written returns its old value.
- R5: A read of register 15 on either port, and the `pc_o` output, both return {6'b0, stored 24-bit word, 2'b0}.
- R6: A general write to register 15 stores only bits 25:2 of `wr_data_i`.
- R7: When `pc_wr_en_i` and a general write to register 15 occur in the same cycle, the program-counter port wins, and bits 25:2 of `pc_wr_data_i` are stored.
- R8: While `user_bank_i` is 1, reads and writes reach the user-mode copies whatever `mode_i` is.
- R9: Asserting `rst_ni` low clears every physical copy and the program counter to zero, without waiting for a clock.
- R10: The two read ports are independent. Each one returns the register it selects in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Current operating mode |
| user_bank_i | input | 1 | Force access to user-mode copies |
| rd_a_sel_i | input | 4 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_sel_i | input | 4 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General write enable |
| wr_sel_i | input | 4 | General write register number |
| wr_data_i | input | 32 | General write data |
| pc_wr_en_i | input | 1 | Program-counter write enable |
| pc_wr_data_i | input | 32 | Program-counter write data (byte address) |
| pc_o | output | 32 | Current program counter as a byte address |

## Verification
A wrong mapping from register number and mode to a physical copy does not show at once. It appears on a read port only when the stale or foreign copy is read later, and it can even show in a different mode from the one that did the write. For that reason, each write is followed by a read in a chosen second mode, and the result is compared with what the banking rules predict. Errors in the program counter show on `pc_o` one cycle after the faulty write. A missing or extra bypass shows within the write cycle itself, as a read that returns the new value too early.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  typedef enum logic [1:0] {
    MODE_USR = 2'd0,
    MODE_FIQ = 2'd1,
    MODE_IRQ = 2'd2,
    MODE_SVC = 2'd3
  } cpu_mode_e;

  localparam int NUM_MODES   = 4;
  localparam int SEL_W       = 4;
  localparam int SHARED_CNT  = 8;   // regs 0..7
  localparam int FIQ_LO      = 8;   // regs 8..12: fiq vs rest
  localparam int FIQ_HI      = 12;
  localparam int FULL_LO     = 13;  // regs 13..14: one per mode
  localparam int FULL_HI     = 14;
  localparam int PC_SEL      = 15;
  localparam int FIQ_CNT     = FIQ_HI - FIQ_LO + 1;
  localparam int FULL_CNT    = FULL_HI - FULL_LO + 1;
  localparam int FIQ_BASE    = FIQ_HI + 1;
  localparam int FULL_BASE   = FIQ_BASE + FIQ_CNT;
  localparam int NUM_PHYS    = FULL_BASE + FULL_CNT * NUM_MODES;
  localparam int PHYS_W      = $clog2(NUM_PHYS);
endpackage

// File: rtl/regfile_bank_map.sv
module regfile_bank_map
  import regfile_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  cpu_mode_e         mode_i,
  output logic [PHYS_W-1:0] idx_o,
  output logic              is_pc_o
);
  int sel_n;

  always_comb begin
    sel_n   = int'(sel_i);
    is_pc_o = (sel_n == PC_SEL);
    if (sel_n < SHARED_CNT)
      idx_o = PHYS_W'(sel_n);
    else if (sel_n <= FIQ_HI)
      idx_o = (mode_i == MODE_FIQ) ? PHYS_W'(sel_n - FIQ_LO + FIQ_BASE) : PHYS_W'(sel_n);
    else if (sel_n <= FULL_HI)
      idx_o = PHYS_W'(FULL_BASE + (sel_n - FULL_LO) * NUM_MODES + int'(mode_i));
    else
      idx_o = '0;
  end
endmodule

// File: rtl/regfile_store.sv
module regfile_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 26,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem[g] <= '0;
      else if (we_i && waddr_i == AW'(g))
        mem[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_a_o = (int'(raddr_a_i) < DEPTH) ? mem[raddr_a_i] : '0;
    rdata_b_o = (int'(raddr_b_i) < DEPTH) ? mem[raddr_b_i] : '0;
  end
endmodule

// File: rtl/regfile_pc.sv
module regfile_pc #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 24,
  parameter int PC_LSB = 2,
  localparam int PAD_W = DATA_W - PC_W - PC_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pc_we_i,
  input  logic [DATA_W-1:0] pc_wdata_i,
  input  logic              gen_we_i,
  input  logic [DATA_W-1:0] gen_wdata_i,
  output logic [DATA_W-1:0] pc_full_o
);
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      pc_q <= '0;
    else if (pc_we_i)   // dedicated port wins
      pc_q <= pc_wdata_i[PC_LSB +: PC_W];
    else if (gen_we_i)
      pc_q <= gen_wdata_i[PC_LSB +: PC_W];
  end

  assign pc_full_o = {{PAD_W{1'b0}}, pc_q, {PC_LSB{1'b0}}};
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              user_bank_i,
  input  logic [3:0]        rd_a_sel_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_sel_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pc_wr_en_i,
  input  logic [DATA_W-1:0] pc_wr_data_i,
  output logic [DATA_W-1:0] pc_o
);
  localparam int PC_LSB = 2;
  localparam int NPORT  = 3;  // read a, read b, write

  cpu_mode_e         eff_mode;
  logic [SEL_W-1:0]  sel    [NPORT];
  logic [PHYS_W-1:0] idx    [NPORT];
  logic              is_pc  [NPORT];
  logic [DATA_W-1:0] st_a, st_b, pc_full;

  assign eff_mode = user_bank_i ? MODE_USR : cpu_mode_e'(mode_i);
  assign sel[0]   = rd_a_sel_i;
  assign sel[1]   = rd_b_sel_i;
  assign sel[2]   = wr_sel_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    regfile_bank_map u_map (
      .sel_i   (sel[p]),
      .mode_i  (eff_mode),
      .idx_o   (idx[p]),
      .is_pc_o (is_pc[p])
    );
  end

  regfile_store #(.DATA_W(DATA_W), .DEPTH(NUM_PHYS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en_i && !is_pc[2]),
    .waddr_i   (idx[2]),
    .wdata_i   (wr_data_i),
    .raddr_a_i (idx[0]),
    .raddr_b_i (idx[1]),
    .rdata_a_o (st_a),
    .rdata_b_o (st_b)
  );

  regfile_pc #(.DATA_W(DATA_W), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_pc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pc_we_i     (pc_wr_en_i),
    .pc_wdata_i  (pc_wr_data_i),
    .gen_we_i    (wr_en_i && is_pc[2]),
    .gen_wdata_i (wr_data_i),
    .pc_full_o   (pc_full)
  );

  assign rd_a_data_o = is_pc[0] ? pc_full : st_a;
  assign rd_b_data_o = is_pc[1] ? pc_full : st_b;
  assign pc_o        = pc_full;
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              user_bank_i,
  input logic [3:0]        rd_a_sel_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [3:0]        rd_b_sel_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              wr_en_i,
  input logic [3:0]        wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              pc_wr_en_i,
  input logic [DATA_W-1:0] pc_wr_data_i,
  input logic [DATA_W-1:0] pc_o
);
  logic       past_ok;
  logic [1:0] eff;

  assign eff = user_bank_i ? 2'd0 : mode_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  a_r4_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(wr_en_i && wr_sel_i != 4'hF) && rd_a_sel_i == $past(wr_sel_i)
      && eff == $past(eff) |-> rd_a_data_o == $past(wr_data_i));

  a_r1_shared_any_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(wr_en_i && wr_sel_i < 4'd8) && rd_b_sel_i == $past(wr_sel_i)
      |-> rd_b_data_o == $past(wr_data_i));

  a_r7_pc_port_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(pc_wr_en_i) |-> pc_o[PC_W+1:2] == $past(pc_wr_data_i[PC_W+1:2]));

  a_r5_pc_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00 && pc_o[DATA_W-1:PC_W+2] == '0);

  a_r5_r15_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_sel_i == 4'hF |-> rd_a_data_o == pc_o);

  a_r9_pc_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !past_ok |-> pc_o == '0);
endmodule

bind bank_regfile bank_regfile_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .user_bank_i  (user_bank_i),
  .rd_a_sel_i   (rd_a_sel_i),
  .rd_a_data_o  (rd_a_data_o),
  .rd_b_sel_i   (rd_b_sel_i),
  .rd_b_data_o  (rd_b_data_o),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .pc_wr_en_i   (pc_wr_en_i),
  .pc_wr_data_i (pc_wr_data_i),
  .pc_o         (pc_o)
);

// File: tb/bank_regfile_test.sv
`timescale 1ns/1ps
module bank_regfile_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        user_bank_i = 1'b0;
  logic [3:0]  rd_a_sel_i = '0, rd_b_sel_i = '0, wr_sel_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0, pc_wr_data_i = '0, pc_o;
  logic        wr_en_i = 1'b0, pc_wr_en_i = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  bank_regfile uut (.*);

  // {req[81:78], wmode, wub, wsel, wdata, rmode, rub, rsel, expected}
  localparam int NV = 17;
  localparam logic [81:0] VEC [NV] = '{
    {4'd1,  2'd0,1'b0,4'd3, 32'h11111111, 2'd3,1'b0,4'd3, 32'h11111111}, // R1
    {4'd1,  2'd1,1'b0,4'd5, 32'h00000022, 2'd2,1'b0,4'd5, 32'h00000022}, // R1
    {4'd2,  2'd0,1'b0,4'd9, 32'h000000A9, 2'd1,1'b0,4'd9, 32'h00000000}, // R2
    {4'd2,  2'd1,1'b0,4'd9, 32'h000000F9, 2'd3,1'b0,4'd9, 32'h000000A9}, // R2
    {4'd2,  2'd2,1'b0,4'd10,32'h00001010, 2'd0,1'b0,4'd10,32'h00001010}, // R2
    {4'd2,  2'd1,1'b0,4'd12,32'h00000C12, 2'd1,1'b0,4'd12,32'h00000C12}, // R2
    {4'd3,  2'd0,1'b0,4'd13,32'h00001300, 2'd2,1'b0,4'd13,32'h00000000}, // R3
    {4'd3,  2'd2,1'b0,4'd13,32'h00001302, 2'd3,1'b0,4'd13,32'h00000000}, // R3
    {4'd3,  2'd3,1'b0,4'd13,32'h00001303, 2'd1,1'b0,4'd13,32'h00000000}, // R3
    {4'd3,  2'd1,1'b0,4'd14,32'h00001401, 2'd0,1'b0,4'd14,32'h00000000}, // R3
    {4'd3,  2'd3,1'b0,4'd14,32'h00001403, 2'd3,1'b0,4'd14,32'h00001403}, // R3
    {4'd8,  2'd3,1'b1,4'd13,32'h000000AB, 2'd0,1'b0,4'd13,32'h000000AB}, // R8
    {4'd8,  2'd2,1'b0,4'd8, 32'h00000088, 2'd1,1'b1,4'd8, 32'h00000088}, // R8
    {4'd3,  2'd3,1'b0,4'd13,32'h00001333, 2'd2,1'b0,4'd13,32'h00001302}, // R3
    {4'd6,  2'd0,1'b0,4'd15,32'hFFFFFFFF, 2'd2,1'b0,4'd15,32'h03FFFFFC}, // R6
    {4'd3,  2'd2,1'b0,4'd14,32'h00001402, 2'd1,1'b0,4'd14,32'h00001401}, // R3
    {4'd8,  2'd1,1'b1,4'd14,32'h00001400, 2'd0,1'b0,4'd14,32'h00001400}  // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    #1;
    // R9: reset clears everything
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 16; s++) begin
        mode_i = 2'(m); rd_a_sel_i = 4'(s); #1;
        chk("R9 reset state", rd_a_data_o, 32'h0);
      end
    chk("R9 reset pc", pc_o, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [81:0] v;
      v = VEC[i];
      @(negedge clk_i);
      mode_i = v[77:76]; user_bank_i = v[75]; wr_sel_i = v[74:71];
      wr_data_i = v[70:39]; wr_en_i = 1'b1;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      mode_i = v[38:37]; user_bank_i = v[36]; rd_a_sel_i = v[35:32];
      #1 chk($sformatf("R%0d vector %0d", v[81:78], i), rd_a_data_o, v[31:0]);
    end

    // R10: independent read ports
    @(negedge clk_i);
    mode_i = 2'd0; user_bank_i = 1'b0; rd_a_sel_i = 4'd3; rd_b_sel_i = 4'd15;
    #1 chk("R10 port a", rd_a_data_o, 32'h11111111);
    chk("R10 port b pc", rd_b_data_o, 32'h03FFFFFC);
    mode_i = 2'd1; rd_a_sel_i = 4'd9; rd_b_sel_i = 4'd12;
    #1 chk("R10 port a fiq", rd_a_data_o, 32'h000000F9);
    chk("R10 port b fiq", rd_b_data_o, 32'h00000C12);

    // R4: no bypass, edge-sampled mode
    @(negedge clk_i);
    mode_i = 2'd0; wr_sel_i = 4'd2; wr_data_i = 32'h55; wr_en_i = 1'b1; rd_a_sel_i = 4'd2;
    #1 chk("R4 same-cycle old value", rd_a_data_o, 32'h0);
    @(negedge clk_i); wr_en_i = 1'b0;
    #1 chk("R4 after edge", rd_a_data_o, 32'h55);
    @(negedge clk_i);
    mode_i = 2'd1; wr_sel_i = 4'd11; wr_data_i = 32'hB1; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; mode_i = 2'd0; rd_a_sel_i = 4'd11;
    #1 chk("R4 mode at edge (user copy)", rd_a_data_o, 32'h0);
    mode_i = 2'd1;
    #1 chk("R4 mode at edge (fiq copy)", rd_a_data_o, 32'hB1);

    // R7: pc port wins over general r15 write
    @(negedge clk_i);
    pc_wr_en_i = 1'b1; pc_wr_data_i = 32'hFC001237;
    wr_en_i = 1'b1; wr_sel_i = 4'd15; wr_data_i = 32'hFFFFFFFF;
    @(negedge clk_i);
    pc_wr_en_i = 1'b0; wr_en_i = 1'b0; rd_a_sel_i = 4'd15;
    #1 chk("R7 pc priority", pc_o, 32'h00001234);
    chk("R5 r15 read format", rd_a_data_o, 32'h00001234);

    // R9: reset mid-run, asynchronous
    @(negedge clk_i);
    #0.5 rst_ni = 1'b0;
    mode_i = 2'd3; rd_a_sel_i = 4'd14; rd_b_sel_i = 4'd3;
    #0.5 chk("R9 async pc clear", pc_o, 32'h0);
    chk("R9 svc r14 clear", rd_a_data_o, 32'h0);
    chk("R9 r3 clear", rd_b_data_o, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    mode_i = 2'd1; rd_a_sel_i = 4'd9;
    #1 chk("R9 fiq r9 clear", rd_a_data_o, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule